// File: doc/BRIEF.md
# Link Self-Test Pattern Engine

This block provides a built-in bit-error test for a parallel-to-serial video link. Its transmit half sits on the parallel input path. Its receive half watches the words that come back from the far end. A single enable input switches both halves between normal operation and test operation.

In normal operation the transmit path forwards the parallel data word, and the shared status pin carries the data-enable signal. In test operation the transmit path sends a PRBS-7 word stream in place of the data. The receive half seeds itself from the incoming stream and predicts every later word. The shared status pin then reports the result of the comparison.

The result on the status pin comes in two forms, chosen by a view-select input:
- a live flag that reflects only the most recent word;
- a sticky flag that holds any error until test mode is left.

Top module: `link_selftest`

## Requirements
- R1: While `rst_n` is low, `tx_data_out` is all zeros and the checker holds no lock and no error.
- R2: With `test_en` low, `tx_data_out` equals the `tx_data_in` value sampled on the previous rising clock edge.
- R3: With `test_en` low, `status_out` follows `de_in` with no clock delay.
- R4: With `test_en` high, `tx_data_out` carries a PRBS-7 stream with recurrence b[n] = b[n-7] xor b[n-6]. The seed history is all ones. Each word carries DATA_W consecutive bits, and the earliest bit goes in the most significant position. The first word appears after the first rising edge with `test_en` high. Each new entry into test mode restarts the stream from the seed.
- R5: The checker loads its prediction state from the low 7 bits of a received word. It reports no error until LOCK_WORDS consecutive received words have matched the prediction. A mismatch before lock reloads the state from the received word and restarts the count.
- R6: With `test_en` high, `status_out` is 1 for no error and 0 for a detected bit error, and `de_in` has no effect on it.
- R7: With `latch_sel` low, a corrupted word after lock drives `status_out` to 0 for exactly one clock cycle, starting after the edge on which that word is received.
- R8: With `latch_sel` high, `status_out` stays 0 from the first error after lock until `test_en` falls or reset is applied.
- R9: Dropping `test_en` clears the lock and the sticky error. A new entry into test mode must lock again before it can report.
- R10: The live and sticky indications are both tracked at all times. Changing `latch_sel` switches `status_out` between them at once.
- R11: The transmit-side generator state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-side word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | 1 selects test operation on both halves |
| latch_sel | input | 1 | 1 shows the sticky result, 0 the live result |
| tx_data_in | input | DATA_W | Parallel data word in normal operation |
| tx_data_out | output | DATA_W | Registered word toward the serializer |
| rx_data_in | input | DATA_W | Word received from the far end |
| de_in | input | 1 | Data-enable passed to the status pin in normal operation |
| status_out | output | 1 | Data-enable in normal operation, pass/fail in test operation |

## Verification
A corrupted prediction state in the checker appears on `status_out` one cycle after the next compare. After lock it goes low for every word in live view, and it stays low in sticky view. A lock counter that fires early or late shifts the lock boundary by whole words. The bench catches this by placing a single-bit error on exactly the last pre-lock compare and another on the first post-lock compare. A fault in the generator recurrence or seed shows up in `tx_data_out` on the first test word. A fault in the normal-mode path shows up one cycle after any input word.

// File: rtl/lst_pkg.sv
`timescale 1ns/1ps
package lst_pkg;
    // PRBS-7 register length and feedback taps (x^7 + x^6 + 1)
    localparam int unsigned PRBS_LEN = 7;
    localparam int unsigned TAP_HI   = 6;
    localparam int unsigned TAP_LO   = 5;

    typedef logic [PRBS_LEN-1:0] prbs_state_t;
endpackage

// File: rtl/lst_prbs_step.sv
`timescale 1ns/1ps
// Advances a PRBS-7 register by DATA_W bit times and returns the word produced.
module lst_prbs_step
    import lst_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  prbs_state_t       state_i,
    output logic [DATA_W-1:0] word_o,
    output prbs_state_t       next_o
);
    prbs_state_t walk;
    logic        fb;

    always_comb begin
        walk   = state_i;
        word_o = '0;
        fb     = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            fb                 = walk[TAP_HI] ^ walk[TAP_LO];
            word_o[DATA_W-1-i] = fb;
            walk               = {walk[PRBS_LEN-2:0], fb};
        end
        next_o = walk;
    end
endmodule

// File: rtl/lst_pattern_gen.sv
`timescale 1ns/1ps
// Transmit side: registered mux between the parallel data and the PRBS word stream.
module lst_pattern_gen
    import lst_pkg::*;
#(
    parameter int unsigned DATA_W = 10,
    parameter prbs_state_t SEED   = 7'h7F
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              test_en_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        prbs_state_t       lfsr;
    } gen_regs_t;

    localparam gen_regs_t RST_VAL = '{tx: '0, lfsr: SEED};

    gen_regs_t         gen_d, gen_q;
    logic [DATA_W-1:0] step_word;
    prbs_state_t       step_next;

    lst_prbs_step #(.DATA_W(DATA_W)) u_step (
        .state_i (gen_q.lfsr),
        .word_o  (step_word),
        .next_o  (step_next)
    );

    always_comb begin
        gen_d = gen_q;
        if (test_en_i) begin
            gen_d.tx   = step_word;
            gen_d.lfsr = step_next;
        end else begin
            gen_d.tx   = data_i;
            gen_d.lfsr = SEED;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gen_q <= RST_VAL;
        else         gen_q <= gen_d;
    end

    assign data_o = gen_q.tx;

    AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gen_q.lfsr != '0); // R11
endmodule

// File: rtl/lst_pattern_chk.sv
`timescale 1ns/1ps
// Receive side: self-seeding predictor, lock counter, live and sticky error flags.
module lst_pattern_chk
    import lst_pkg::*;
#(
    parameter int unsigned DATA_W     = 10,
    parameter int unsigned LOCK_WORDS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              test_en_i,
    input  logic              latch_sel_i,
    input  logic [DATA_W-1:0] rx_i,
    output logic              pass_o
);
    localparam int unsigned CNT_W = $clog2(LOCK_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_WORDS - 1);

    typedef struct packed {
        logic             seeded;
        logic             locked;
        logic [CNT_W-1:0] cnt;
        prbs_state_t      exp;
        logic             live_err;
        logic             sticky;
    } chk_regs_t;

    localparam chk_regs_t RST_VAL = '{seeded: 1'b0, locked: 1'b0, cnt: '0,
                                      exp: '0, live_err: 1'b0, sticky: 1'b0};

    chk_regs_t         chk_d, chk_q;
    logic [DATA_W-1:0] exp_word;
    prbs_state_t       exp_next;
    logic              match;

    lst_prbs_step #(.DATA_W(DATA_W)) u_step (
        .state_i (chk_q.exp),
        .word_o  (exp_word),
        .next_o  (exp_next)
    );

    assign match = (rx_i == exp_word);

    always_comb begin
        chk_d = chk_q;
        if (!test_en_i) begin
            chk_d = RST_VAL;
        end else if (!chk_q.seeded) begin
            chk_d.seeded = 1'b1;
            chk_d.exp    = rx_i[PRBS_LEN-1:0];
            chk_d.cnt    = '0;
        end else if (!chk_q.locked) begin
            if (match) begin
                chk_d.exp = exp_next;
                if (chk_q.cnt == CNT_LAST) begin
                    chk_d.locked = 1'b1;
                    chk_d.cnt    = '0;
                end else begin
                    chk_d.cnt = chk_q.cnt + 1'b1;
                end
            end else begin
                chk_d.cnt = '0;
                chk_d.exp = rx_i[PRBS_LEN-1:0];
            end
        end else begin
            chk_d.exp      = exp_next;
            chk_d.live_err = !match;
            chk_d.sticky   = chk_q.sticky | !match;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chk_q <= RST_VAL;
        else         chk_q <= chk_d;
    end

    assign pass_o = latch_sel_i ? !chk_q.sticky : !chk_q.live_err;

    AST_QUIET_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chk_q.locked |-> (!chk_q.live_err && !chk_q.sticky)); // R5
    AST_LOCK_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(chk_q.locked) |-> ($past(chk_q.cnt) == CNT_LAST)); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chk_q.sticky && test_en_i) |=> chk_q.sticky); // R8
    AST_EXIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !test_en_i |=> (!chk_q.locked && !chk_q.sticky && !chk_q.seeded)); // R9
endmodule

// File: rtl/link_selftest.sv
`timescale 1ns/1ps
module link_selftest
    import lst_pkg::*;
#(
    parameter int unsigned DATA_W     = 10,
    parameter int unsigned LOCK_WORDS = 8,
    parameter prbs_state_t SEED       = 7'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              latch_sel,
    input  logic [DATA_W-1:0] tx_data_in,
    output logic [DATA_W-1:0] tx_data_out,
    input  logic [DATA_W-1:0] rx_data_in,
    input  logic              de_in,
    output logic              status_out
);
    logic chk_pass;

    lst_pattern_gen #(.DATA_W(DATA_W), .SEED(SEED)) u_gen (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .test_en_i (test_en),
        .data_i    (tx_data_in),
        .data_o    (tx_data_out)
    );

    lst_pattern_chk #(.DATA_W(DATA_W), .LOCK_WORDS(LOCK_WORDS)) u_chk (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .test_en_i   (test_en),
        .latch_sel_i (latch_sel),
        .rx_i        (rx_data_in),
        .pass_o      (chk_pass)
    );

    // Shared pin: data-enable in normal operation, pass/fail in test operation
    assign status_out = test_en ? chk_pass : de_in;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_en) |-> status_out); // R5
endmodule

// File: tb/link_selftest_bench.sv
`timescale 1ns/1ps
module link_selftest_bench;
    localparam int W     = 10;
    localparam int LOCKW = 8;

    logic         clk = 1'b0;
    logic         rst_n, test_en, latch_sel, de_in;
    logic [W-1:0] tx_in, tx_out, rx_in, err_mask;
    logic         status;

    always #2.5 clk = ~clk;

    assign rx_in = tx_out ^ err_mask;

    link_selftest #(.DATA_W(W), .LOCK_WORDS(LOCKW), .SEED(7'h7F)) u_link_selftest (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_en     (test_en),
        .latch_sel   (latch_sel),
        .tx_data_in  (tx_in),
        .tx_data_out (tx_out),
        .rx_data_in  (rx_in),
        .de_in       (de_in),
        .status_out  (status)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic ref_bits [0:1599];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Word k of the reference stream (earliest bit in the MSB)
    function automatic logic [W-1:0] ref_word(input int k);
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) w[W-1-i] = ref_bits[7 + k*W + i];
        return w;
    endfunction

    initial begin
        for (int n = 0; n < 1600; n++)
            ref_bits[n] = (n < 7) ? 1'b1 : (ref_bits[n-7] ^ ref_bits[n-6]);
    end

    initial begin
        rst_n = 1'b0; test_en = 1'b0; latch_sel = 1'b0; de_in = 1'b0;
        tx_in = '0; err_mask = '0;
        repeat (3) @(negedge clk);
        check("R1 reset tx word", tx_out, 0);
        check("R3 reset status low", status, 0);
        de_in = 1'b1; #1;
        check("R3 reset status high", status, 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R3: full sweep of the data word in normal operation
        for (int v = 0; v <= 1024; v++) begin
            @(negedge clk);
            if (v > 0) check("R2 passthrough", tx_out, v - 1);
            if (v < 1024) begin
                tx_in = W'(v);
                de_in = v[0];
                #1;
                check("R3 de follow", status, v[0]);
            end
        end

        // R4 / R6: enter test mode, check the whole PRBS period plus margin
        @(negedge clk);
        test_en = 1'b1; latch_sel = 1'b0; tx_in = '1;
        for (int k = 0; k < 130; k++) begin
            @(negedge clk);
            check("R4 prbs word", tx_out, ref_word(k));
            check("R6 status clean", status, 1);
            de_in = ~de_in;
            #1;
            check("R6 de ignored", status, 1);
        end

        // R7: single-bit error in every position, live view
        for (int b = 0; b < W; b++) begin
            @(negedge clk);
            err_mask = W'(1) << b;
            @(negedge clk);
            check("R7 live error low", status, 0);
            err_mask = '0;
            @(negedge clk);
            check("R7 live error clears", status, 1);
            @(negedge clk);
            check("R7 live stays clear", status, 1);
        end

        // R10: sticky flag was collected during the live sweep
        latch_sel = 1'b1; #1;
        check("R10 sticky view low", status, 0);
        latch_sel = 1'b0; #1;
        check("R10 live view high", status, 1);

        // R9: leaving test mode clears everything
        @(negedge clk);
        test_en = 1'b0; de_in = 1'b1; #1;
        check("R9 exit shows de", status, 1);
        @(negedge clk);
        test_en = 1'b1; latch_sel = 1'b1;
        @(negedge clk);
        check("R4 restart from seed", tx_out, ref_word(0));
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check("R9 sticky cleared", status, 1);
        end

        // R8: sticky error holds
        err_mask = W'(1) << 3;
        @(negedge clk);
        err_mask = '0;
        check("R8 sticky set", status, 0);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check("R8 sticky holds", status, 0);
        end
        latch_sel = 1'b0; #1;
        check("R10 switch to live", status, 1);
        latch_sel = 1'b1; #1;
        check("R10 switch to sticky", status, 0);

        // R5: frequent errors keep the checker from locking
        @(negedge clk);
        test_en = 1'b0;
        @(negedge clk);
        test_en = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i > 0) check("R5 no report before lock", status, 1);
            err_mask = (i % 5 == 0) ? W'(1) : '0;
        end
        // R5 boundary: error on the last pre-lock compare, then on the first locked one
        for (int i = 0; i <= 20; i++) begin
            @(negedge clk);
            if (i > 0) check("R5 lock boundary", status, (i == 20) ? 1'b0 : 1'b1);
            err_mask = (i == 0 || i == 9 || i == 19) ? W'(1) : '0;
        end
        err_mask = '0;

        // R1: reset in the middle of test mode
        rst_n = 1'b0; #1;
        check("R1 reset clears tx", tx_out, 0);
        check("R1 reset clears sticky", status, 1);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule